// File: doc/BRIEF.md
# Request/Wait Bus Link with Variable-Latency Servant

This block pairs both ends of a single-master request/wait bus. A command port starts one transfer at a time. The master drives a request line together with a direction bit, an address and write data. A servant decodes each request against a small local register file. For every access the servant takes its latency from a configuration input.

When the latency fits inside the fixed access time, the servant places its result quietly and the master samples it at the deadline. When the latency is longer, the servant raises a wait line early and drops it at the moment the access completes. The falling edge of wait tells the master that read data is on the bus, or that write data has been stored. The master then takes the result, releases the request and reports completion.

The bus signals are brought out so that the protocol can be observed directly.

Top module: `rwb_link`

## Requirements
- R1: Synchronous active-high reset drives bus_req, bus_wait, busy and done low and clears every register-file word to zero, including a reset that arrives in the middle of a slow access.
- R2: A cmd_start seen at a clock edge while busy is low raises bus_req at that edge (cycle 0). With effective latency L and access time T (parameter ACCESS_T, default 3), done is high for exactly one cycle, in cycle max(T,L)+1.
- R3: Fast path, when L <= T: bus_wait stays low for the whole transfer, and bus_req stays high for cycles 0 through T.
- R4: Slow path, when L > T: bus_wait rises in cycle 1, stays high for L-1 cycles, and falls in cycle L while bus_req is still high. done_slow is 1 on completion, and 0 for fast transfers.
- R5: A read (cmd_write = 0) returns on done_rdata the word last written to that address, or zero if the address was never written.
- R6: A write (cmd_write = 1) stores cmd_wdata at cmd_addr by the time wait falls or the deadline passes. done_rdata is zero for a write.
- R7: bus_req falls at the same edge at which done rises. A new request never rises while bus_wait is high.
- R8: A cmd_start while busy is high is ignored. The transfer in flight keeps its own address, direction and data, and no second completion or store takes place.
- R9: bus_addr, bus_write and bus_wdata hold steady for as long as bus_req stays high.
- R10: A configured latency of 0 behaves exactly as a latency of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Starts a transfer when idle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | AW | Register address |
| cmd_wdata | input | DW | Write data |
| cfg_latency | input | LW | Servant latency in cycles for the next access (0 is treated as 1) |
| busy | output | 1 | Master has a transfer in flight |
| done | output | 1 | One-cycle completion pulse |
| done_rdata | output | DW | Data captured on completion |
| done_slow | output | 1 | Completed transfer used the wait line |
| bus_req | output | 1 | Bus request line |
| bus_wait | output | 1 | Bus wait line driven by the servant |
| bus_write | output | 1 | Bus direction |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data |
| bus_rdata | output | DW | Bus read data driven by the servant |

## Verification
Cycles are counted from the edge that accepts cmd_start, which is cycle 0 on the bus. The done pulse is due in cycle max(ACCESS_T, L)+1. The bench therefore counts edges until done appears and compares that count with max(ACCESS_T, L)+2, sampling at the falling clock edge. On every sample of the same walk it tallies the cycles with request high and with wait high, which pins the width of both lines against T+1 or L+1 and against L-1. Stores are checked through later reads, and the stimulus table interleaves latencies below, at and above the deadline.

// File: rtl/rwb_pkg.sv
package rwb_pkg;

    typedef enum logic [1:0] {
        M_IDLE = 2'd0,
        M_REQ  = 2'd1,
        M_WAIT = 2'd2
    } mst_state_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_BUSY = 2'd1,
        S_HOLD = 2'd2
    } srv_state_e;

    // A configured latency of zero is served as one cycle.
    function automatic int unsigned effective_latency(input int unsigned raw);
        return (raw == 0) ? 1 : raw;
    endfunction

endpackage

// File: rtl/rwb_regfile.sv
module rwb_regfile #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) words[i] <= '0;
        end else if (wr_en) begin
            words[wr_addr] <= wr_data;
        end
    end

    assign rd_data = words[rd_addr];
endmodule

// File: rtl/rwb_master.sv
module rwb_master
    import rwb_pkg::*;
#(
    parameter int AW       = 4,
    parameter int DW       = 8,
    parameter int ACCESS_T = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_start,
    input  logic          cmd_write,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] done_rdata,
    output logic          done_slow,
    output logic          bus_req,
    output logic          bus_write,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_wait,
    input  logic [DW-1:0] bus_rdata
);
    localparam int AGE_W = $clog2(ACCESS_T + 1) + 1;
    localparam logic [AGE_W-1:0] AGE_LAST = AGE_W'(ACCESS_T);

    typedef struct packed {
        logic          write;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } xfer_t;

    mst_state_e       st;
    xfer_t            cur;
    logic [AGE_W-1:0] age;
    logic             capture;

    // Result is taken at the deadline with wait low, or at the first low wait after it.
    assign capture = ((st == M_REQ) && (age == AGE_LAST) && !bus_wait)
                  || ((st == M_WAIT) && !bus_wait);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= M_IDLE;
            cur        <= '0;
            age        <= '0;
            bus_req    <= 1'b0;
            done       <= 1'b0;
            done_rdata <= '0;
            done_slow  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st)
                M_IDLE: begin
                    if (cmd_start) begin
                        cur.write <= cmd_write;
                        cur.addr  <= cmd_addr;
                        cur.wdata <= cmd_wdata;
                        bus_req   <= 1'b1;
                        age       <= '0;
                        st        <= M_REQ;
                    end
                end
                M_REQ: begin
                    if (age != AGE_LAST) begin
                        age <= age + AGE_W'(1);
                    end else if (bus_wait) begin
                        st <= M_WAIT;
                    end
                end
                M_WAIT: ;
                default: st <= M_IDLE;
            endcase
            if (capture) begin
                done       <= 1'b1;
                done_rdata <= bus_rdata;
                done_slow  <= (st == M_WAIT);
                bus_req    <= 1'b0;
                st         <= M_IDLE;
            end
        end
    end

    assign busy      = (st != M_IDLE);
    assign bus_write = cur.write;
    assign bus_addr  = cur.addr;
    assign bus_wdata = cur.wdata;
endmodule

// File: rtl/rwb_servant.sv
module rwb_servant
    import rwb_pkg::*;
#(
    parameter int AW       = 4,
    parameter int DW       = 8,
    parameter int LW       = 4,
    parameter int ACCESS_T = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [LW-1:0] cfg_latency,
    input  logic          bus_req,
    input  logic          bus_write,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic          bus_wait,
    output logic [DW-1:0] bus_rdata,
    output logic          rf_wr_en,
    output logic [AW-1:0] rf_addr,
    output logic [DW-1:0] rf_wdata,
    input  logic [DW-1:0] rf_rdata
);
    srv_state_e    st;
    logic [LW-1:0] lat_q;
    logic [LW-1:0] elapsed;
    logic [LW-1:0] lat_in;
    logic          slow_in;
    logic          fire;

    assign lat_in  = LW'(effective_latency(int'(cfg_latency)));
    assign slow_in = int'(lat_in) > ACCESS_T;

    // The access completes on the edge where the elapsed count reaches the latency.
    assign fire = ((st == S_IDLE) && bus_req && (lat_in == LW'(1)))
               || ((st == S_BUSY) && ((elapsed + LW'(1)) == lat_q));

    assign rf_wr_en = fire && bus_write;
    assign rf_addr  = bus_addr;
    assign rf_wdata = bus_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_IDLE;
            lat_q     <= '0;
            elapsed   <= '0;
            bus_wait  <= 1'b0;
            bus_rdata <= '0;
        end else begin
            unique case (st)
                S_IDLE: begin
                    if (bus_req && !fire) begin
                        lat_q    <= lat_in;
                        elapsed  <= LW'(1);
                        bus_wait <= slow_in;
                        st       <= S_BUSY;
                    end
                end
                S_BUSY: begin
                    elapsed <= elapsed + LW'(1);
                end
                S_HOLD: begin
                    if (!bus_req) begin
                        bus_rdata <= '0;
                        st        <= S_IDLE;
                    end
                end
                default: st <= S_IDLE;
            endcase
            if (fire) begin
                bus_rdata <= bus_write ? '0 : rf_rdata;
                bus_wait  <= 1'b0;
                st        <= S_HOLD;
            end
        end
    end
endmodule

// File: rtl/rwb_link.sv
module rwb_link #(
    parameter int AW       = 4,
    parameter int DW       = 8,
    parameter int LW       = 4,
    parameter int ACCESS_T = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_start,
    input  logic          cmd_write,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    input  logic [LW-1:0] cfg_latency,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] done_rdata,
    output logic          done_slow,
    output logic          bus_req,
    output logic          bus_wait,
    output logic          bus_write,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata
);
    logic          rf_wr_en;
    logic [AW-1:0] rf_addr;
    logic [DW-1:0] rf_wdata;
    logic [DW-1:0] rf_rdata;

    rwb_master #(.AW(AW), .DW(DW), .ACCESS_T(ACCESS_T)) u_master (
        .clk(clk), .rst(rst),
        .cmd_start(cmd_start), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .busy(busy), .done(done), .done_rdata(done_rdata), .done_slow(done_slow),
        .bus_req(bus_req), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wait(bus_wait), .bus_rdata(bus_rdata)
    );

    rwb_servant #(.AW(AW), .DW(DW), .LW(LW), .ACCESS_T(ACCESS_T)) u_servant (
        .clk(clk), .rst(rst), .cfg_latency(cfg_latency),
        .bus_req(bus_req), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wait(bus_wait), .bus_rdata(bus_rdata),
        .rf_wr_en(rf_wr_en), .rf_addr(rf_addr),
        .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
    );

    rwb_regfile #(.AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(rf_wr_en), .wr_addr(rf_addr), .wr_data(rf_wdata),
        .rd_addr(rf_addr), .rd_data(rf_rdata)
    );
endmodule

// File: rtl/rwb_link_chk.sv
module rwb_link_chk #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          bus_req,
    input logic          bus_wait,
    input logic          bus_write,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic          done
);
    // Cycles the request has already been high before the current one.
    logic [7:0] req_age;

    always_ff @(posedge clk) begin
        if (rst || !bus_req) req_age <= '0;
        else if (req_age != 8'hFF) req_age <= req_age + 8'd1;
    end

    p_bus_stable_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_req && $past(bus_req)) |->
            ($stable(bus_addr) && $stable(bus_write) && $stable(bus_wdata)));

    p_no_req_under_wait_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req) |-> !bus_wait);

    p_wait_inside_req_r4: assert property (@(posedge clk) disable iff (rst)
        bus_wait |-> bus_req);

    p_wait_early_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_wait) |-> (req_age == 8'd1));

    p_done_with_release_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> (!bus_req && $past(bus_req)));

    p_done_single_r2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

bind rwb_link rwb_link_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_wait(bus_wait),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .done(done)
);

// File: tb/test_rwb_link.sv
`timescale 1ns/1ps
module test_rwb_link;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int LW = 4;
    localparam int T  = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_start = 1'b0;
    logic          cmd_write = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic [LW-1:0] cfg_latency = '0;
    logic          busy, done, done_slow, bus_req, bus_wait, bus_write;
    logic [DW-1:0] done_rdata, bus_wdata, bus_rdata;
    logic [AW-1:0] bus_addr;

    always #2 clk = ~clk;

    rwb_link #(.AW(AW), .DW(DW), .LW(LW), .ACCESS_T(T)) i_rwb_link (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cfg_latency(cfg_latency),
        .busy(busy), .done(done), .done_rdata(done_rdata), .done_slow(done_slow),
        .bus_req(bus_req), .bus_wait(bus_wait), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit ended  = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            finish_run();
        end
    end

    typedef struct packed {
        logic          wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [LW-1:0] lat;
        logic [DW-1:0] exp_rd;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 4'd3,  8'hA5, 4'd1, 8'h00},  // fast write
        '{1'b1, 4'd7,  8'h3C, 4'd5, 8'h00},  // slow write
        '{1'b0, 4'd3,  8'h00, 4'd3, 8'hA5},  // latency equal to deadline
        '{1'b0, 4'd7,  8'h00, 4'd4, 8'h3C},  // one beyond deadline
        '{1'b1, 4'd15, 8'hFF, 4'd2, 8'h00},
        '{1'b0, 4'd15, 8'h00, 4'd9, 8'hFF},
        '{1'b0, 4'd0,  8'h00, 4'd1, 8'h00},  // never written
        '{1'b1, 4'd3,  8'h11, 4'd4, 8'h00},  // slow overwrite
        '{1'b0, 4'd3,  8'h00, 4'd2, 8'h11},
        '{1'b0, 4'd7,  8'h00, 4'd0, 8'h3C}   // latency 0
    };

    int r_cycles, r_req, r_wait, r_done_cnt;
    logic [DW-1:0] r_rd;
    logic r_slow;

    // Issue one transfer; extra_start_at >= 1 pulses a second start while busy.
    task automatic run(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic [LW-1:0] lat, input int extra_start_at);
        @(negedge clk);
        cmd_write = wr; cmd_addr = a; cmd_wdata = d; cfg_latency = lat;
        cmd_start = 1'b1;
        r_cycles = 0; r_req = 0; r_wait = 0; r_done_cnt = 0;
        r_rd = '0; r_slow = 1'b0;
        for (int k = 0; k < 200; k++) begin
            @(posedge clk);
            r_cycles++;
            @(negedge clk);
            cmd_start = 1'b0;
            if (extra_start_at == r_cycles) begin
                cmd_write = 1'b1; cmd_addr = a; cmd_wdata = 8'h77;
                cmd_start = 1'b1;
            end
            if (bus_req) r_req++;
            if (bus_wait) r_wait++;
            if (done) begin
                r_done_cnt++;
                r_rd = done_rdata;
                r_slow = done_slow;
                break;
            end
        end
        cmd_start = 1'b0;
        cmd_write = 1'b0;
        cmd_wdata = '0;
    endtask

    function automatic int eff(input int raw);
        return (raw == 0) ? 1 : raw;
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check(!bus_req && !bus_wait && !busy && !done, "R1 idle after reset",
              {bus_req, bus_wait, busy, done}, 0);

        for (int i = 0; i < NV; i++) begin
            int L, M;
            bit slow;
            L = eff(int'(VEC[i].lat));
            M = (L > T) ? L : T;
            slow = (L > T);
            run(VEC[i].wr, VEC[i].addr, VEC[i].wdata, VEC[i].lat, 0);
            check(r_cycles == M + 2, "R2 done cycle", r_cycles, M + 2);
            check(r_slow == slow, "R4 done_slow", r_slow, slow);
            check(r_req == M + 1, "R3/R4 req width", r_req, M + 1);
            if (slow)
                check(r_wait == L - 1, "R4 wait width", r_wait, L - 1);
            else
                check(r_wait == 0, "R3 no wait on fast path", r_wait, 0);
            if (VEC[i].wr)
                check(r_rd == 0, "R6 write returns zero", r_rd, 0);
            else
                check(r_rd == VEC[i].exp_rd, "R5 read data", r_rd, VEC[i].exp_rd);
            if (VEC[i].lat == 0)
                check(r_cycles == T + 2, "R10 latency zero as one", r_cycles, T + 2);
            @(negedge clk);
            check(!bus_req && !done, "R7 req released after done", {bus_req, done}, 0);
        end

        // R8: start while busy is ignored
        run(1'b0, 4'd3, 8'h00, 4'd8, 2);
        check(r_rd == 8'h11, "R8 in-flight read kept", r_rd, 8'h11);
        check(r_cycles == 10, "R8 in-flight timing kept", r_cycles, 10);
        repeat (12) begin
            @(negedge clk);
            check(!done, "R8 no second completion", done, 0);
        end
        run(1'b0, 4'd3, 8'h00, 4'd1, 0);
        check(r_rd == 8'h11, "R8 no store from ignored start", r_rd, 8'h11);

        // R6: write then read back at a new address, slow write latency 12
        run(1'b1, 4'd9, 8'h5A, 4'd12, 0);
        check(r_cycles == 14, "R6 slow write timing", r_cycles, 14);
        run(1'b0, 4'd9, 8'h00, 4'd3, 0);
        check(r_rd == 8'h5A, "R6 stored word", r_rd, 8'h5A);

        // R1: reset in the middle of a slow access
        @(negedge clk);
        cmd_write = 1'b0; cmd_addr = 4'd9; cfg_latency = 4'd10; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        repeat (3) @(negedge clk);
        check(bus_wait == 1'b1, "R4 wait held mid access", bus_wait, 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(!bus_req && !bus_wait && !busy && !done, "R1 reset mid access",
              {bus_req, bus_wait, busy, done}, 0);
        run(1'b0, 4'd9, 8'h00, 4'd1, 0);
        check(r_rd == 8'h00, "R1 register file cleared", r_rd, 0);
        check(r_done_cnt == 1, "R2 transfer after reset completes", r_done_cnt, 1);

        finish_run();
    end
endmodule